// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block sets the horizontal and vertical timing of an interlaced 525-line or 625-line video path. It runs from the double-rate pixel clock, which is 27 MHz in a real system. When it is the timing master, it counts clock cycles within a line and lines within a frame. From those counts it drives active-low horizontal and vertical sync.

When it is a slave, it leaves both sync pins undriven and follows syncs supplied from outside. A falling edge of the horizontal sync starts a new line. A falling edge of the vertical sync restarts the frame position. The field parity comes from how far the vertical edge lies from the last horizontal edge.

A two-bit standard selector chooses a 525-line standard, a 625-line standard, or sleep. In sleep the timing is parked and the sync outputs stay idle. Downstream logic receives the current line number, the field parity, a blanking flag and a one-cycle pulse at the start of each line.

Top module: `vid_sync_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs hold `hsync_n_out`=1, `vsync_n_out`=1, `sync_oe`=0, `blank`=1, `line_start`=0, `line_num`=1 and `field`=0. The position resets to line 1, cycle 0.
- R2: `std_sel` decodes as follows: 2'b11 and 2'b01 select a frame of FRAME_525 lines of LINE_525 cycles each, 2'b10 selects FRAME_625 lines of LINE_625 cycles each, and 2'b00 selects sleep. In master mode `line_num` counts 1 to the frame length and then returns to 1.
- R3: In master mode `hsync_n_out` is low for the first HS_WIDTH cycles of every line. `line_start` is high for exactly the first cycle of every line.
- R4: In master mode the first field's vertical sync is low from line 1, cycle 0, for VS_LINES whole lines. `field` reads 0 from line 1, cycle 0, onward.
- R5: In master mode the second field's vertical sync is low for VS_LINES lines. It starts at line MID = (frame length + 1)/2, cycle HALF = line length/2. `field` reads 1 from that point until the frame wraps.
- R6: `blank` is high when the cycle within the line is below H_BLANK. It is also high when the line is at most VBLANK_LINES, or lies in MID+1 to MID+VBLANK_LINES.
- R7: With `master_sel`=0 (slave), `sync_oe` is 0 and both sync outputs read 1. A falling edge on `hsync_n_in` restarts the cycle count, advances `line_num` (wrapping after the frame length) and produces one `line_start` pulse. Without such an edge the cycle count saturates at 2^ceil(log2(longest line + 1)) - 1.
- R8: In slave mode a falling edge on `vsync_n_in` is counted as aligned in two cases: it comes together with an `hsync_n_in` falling edge, or fewer than line length/4 cycles have passed since the last one. An aligned edge sets line 1 and `field` 0. Any other edge sets line MID and `field` 1.
- R9: In sleep (`std_sel`=2'b00) the sync outputs are 1, `blank` is 1, `line_start` is 0, `line_num` is 1 and `field` is 0. `sync_oe` follows `master_sel`. On leaving sleep, master timing restarts at line 1, cycle 0.
- R10: A change of standard in the middle of a line never runs the cycle count past the new line length. Any count at or above the new length minus one ends the line on the next edge.
- R11: All outputs are registered. The values seen after a clock edge describe the position held before that edge. After reset is released in master mode, the first output cycle shows line 1, cycle 0: `line_start` is 1 and `hsync_n_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = generate sync, 0 = follow external sync |
| std_sel | input | 2 | Standard selector: 11/01 525-line, 10 625-line, 00 sleep |
| hsync_n_in | input | 1 | External horizontal sync, active low (slave mode) |
| vsync_n_in | input | 1 | External vertical sync, active low (slave mode) |
| hsync_n_out | output | 1 | Generated horizontal sync, active low |
| vsync_n_out | output | 1 | Generated vertical sync, active low |
| sync_oe | output | 1 | High when the sync outputs should drive the pins |
| blank | output | 1 | Blanking interval flag |
| line_start | output | 1 | One-cycle pulse at the first cycle of each line |
| line_num | output | LW | Current line number, from 1 |
| field | output | 1 | 0 = first field, 1 = second field |

## Verification
In master mode every output is due one edge after the position it describes. A change of standard or of the master select therefore shows in the outputs one edge after it is sampled. In slave mode an external sync edge is sampled at edge E and moves the position at E. It reaches `line_start`, `line_num` and `field` at E+1, so the result is visible two edges after the input change. The bench drives inputs on the falling clock edge. A behavioural model advances on each rising edge, and every output is compared at the following falling edge, so each comparison falls in the cycle where the registered result is due.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  typedef enum logic [1:0] {
    STD_SLEEP = 2'b00,
    STD_M525  = 2'b01,
    STD_625   = 2'b10,
    STD_525   = 2'b11
  } std_e;

  function automatic logic std_is_sleep(input logic [1:0] sel);
    return sel == STD_SLEEP;
  endfunction

  function automatic logic std_is_625(input logic [1:0] sel);
    return sel == STD_625;
  endfunction

endpackage

// File: rtl/vsg_std_dec.sv
module vsg_std_dec #(
  parameter int LINE_525  = 1716,
  parameter int LINE_625  = 1728,
  parameter int FRAME_525 = 525,
  parameter int FRAME_625 = 625,
  parameter int PW        = 11,
  parameter int LW        = 10
) (
  input  logic [1:0]    std_sel,
  output logic [PW-1:0] line_len,
  output logic [PW-1:0] half_len,
  output logic [PW-1:0] qtr_len,
  output logic [LW-1:0] frame_len,
  output logic [LW-1:0] mid_line,
  output logic          sleep
);
  import vsg_pkg::*;

  always_comb begin
    sleep = std_is_sleep(std_sel);
    if (std_is_625(std_sel)) begin
      line_len  = PW'(LINE_625);
      frame_len = LW'(FRAME_625);
    end else begin
      line_len  = PW'(LINE_525);
      frame_len = LW'(FRAME_525);
    end
    half_len = line_len >> 1;
    qtr_len  = line_len >> 2;
    mid_line = LW'((int'(frame_len) + 1) / 2);
  end

endmodule

// File: rtl/vsg_edge.sv
module vsg_edge (
  input  logic clk,
  input  logic rst,
  input  logic hsync_n_in,
  input  logic vsync_n_in,
  output logic hs_fall,
  output logic vs_fall
);
  logic [1:0] raw;
  logic [1:0] fall;

  assign raw = {vsync_n_in, hsync_n_in};

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= raw[g];
    end
    assign fall[g] = prev_q & ~raw[g];
  end

  assign hs_fall = fall[0];
  assign vs_fall = fall[1];

endmodule

// File: rtl/vsg_counter.sv
module vsg_counter #(
  parameter int PW = 11,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          sleep,
  input  logic [PW-1:0] line_len,
  input  logic [PW-1:0] qtr_len,
  input  logic [LW-1:0] frame_len,
  input  logic [LW-1:0] mid_line,
  input  logic          hs_fall,
  input  logic          vs_fall,
  output logic [PW-1:0] pix,
  output logic [LW-1:0] line,
  output logic          fld,
  output logic          sl_start
);
  localparam logic [PW-1:0] PIX_SAT = {PW{1'b1}};

  logic [LW-1:0] line_nx;
  logic          aligned;

  assign line_nx = (line >= frame_len) ? LW'(1) : line + LW'(1);
  assign aligned = hs_fall || (pix < qtr_len);

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      pix      <= '0;
      line     <= LW'(1);
      fld      <= 1'b0;
      sl_start <= 1'b0;
    end else if (master) begin
      sl_start <= 1'b0;
      if (pix >= line_len - PW'(1)) begin
        pix  <= '0;
        line <= line_nx;
      end else begin
        pix <= pix + PW'(1);
      end
    end else begin
      sl_start <= hs_fall;
      if (hs_fall) begin
        pix  <= '0;
        line <= line_nx;
      end else if (pix != PIX_SAT) begin
        pix <= pix + PW'(1);
      end
      if (vs_fall) begin
        if (aligned) begin
          line <= LW'(1);
          fld  <= 1'b0;
        end else begin
          line <= mid_line;
          fld  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vsg_outreg.sv
module vsg_outreg #(
  parameter int PW           = 11,
  parameter int LW           = 10,
  parameter int HS_WIDTH     = 64,
  parameter int VS_LINES     = 2,
  parameter int H_BLANK      = 276,
  parameter int VBLANK_LINES = 20,
  parameter int FRAME_MAX    = 625
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          sleep,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  input  logic          fld,
  input  logic          sl_start,
  input  logic [PW-1:0] half_len,
  input  logic [LW-1:0] mid_line,
  output logic          hsync_n_out,
  output logic          vsync_n_out,
  output logic          sync_oe,
  output logic          blank,
  output logic          line_start,
  output logic [LW-1:0] line_num,
  output logic          field
);
  int  pv, lv, mv, hv;
  logic odd_vs, even_vs, pos_field, hblank, vblank;

  always_comb begin
    pv = int'(pix);
    lv = int'(line);
    mv = int'(mid_line);
    hv = int'(half_len);
    odd_vs    = (lv <= VS_LINES);
    even_vs   = (lv == mv && pv >= hv) ||
                (lv > mv && lv < mv + VS_LINES) ||
                (lv == mv + VS_LINES && pv < hv);
    pos_field = (lv > mv) || (lv == mv && pv >= hv);
    hblank    = (pv < H_BLANK);
    vblank    = (lv <= VBLANK_LINES) || (lv > mv && lv <= mv + VBLANK_LINES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n_out <= 1'b1;
      vsync_n_out <= 1'b1;
      sync_oe     <= 1'b0;
      blank       <= 1'b1;
      line_start  <= 1'b0;
      line_num    <= LW'(1);
      field       <= 1'b0;
    end else begin
      sync_oe <= master;
      if (sleep) begin
        hsync_n_out <= 1'b1;
        vsync_n_out <= 1'b1;
        blank       <= 1'b1;
        line_start  <= 1'b0;
        line_num    <= LW'(1);
        field       <= 1'b0;
      end else if (master) begin
        hsync_n_out <= !(pv < HS_WIDTH);
        vsync_n_out <= !(odd_vs || even_vs);
        blank       <= hblank || vblank;
        line_start  <= (pix == '0);
        line_num    <= line;
        field       <= pos_field;
      end else begin
        hsync_n_out <= 1'b1;
        vsync_n_out <= 1'b1;
        blank       <= hblank || vblank;
        line_start  <= sl_start;
        line_num    <= line;
        field       <= fld;
      end
    end
  end

  a_r3_single_start: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  a_r2_line_range: assert property (@(posedge clk) disable iff (rst)
    sync_oe |-> (line_num >= LW'(1) && int'(line_num) <= FRAME_MAX));

  a_r4_line1_first_field: assert property (@(posedge clk) disable iff (rst)
    ($past(master) && line_num == LW'(1)) |-> !field);

  a_r7_slave_undriven: assert property (@(posedge clk) disable iff (rst)
    $past(!master) |-> (!sync_oe && hsync_n_out && vsync_n_out));

  a_r9_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    $past(sleep) |-> (hsync_n_out && vsync_n_out && blank && !line_start));

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int LINE_525     = 1716,
  parameter int LINE_625     = 1728,
  parameter int FRAME_525    = 525,
  parameter int FRAME_625    = 625,
  parameter int HS_WIDTH     = 64,
  parameter int VS_LINES     = 2,
  parameter int H_BLANK      = 276,
  parameter int VBLANK_LINES = 20,
  localparam int LMAX = (LINE_625 > LINE_525) ? LINE_625 : LINE_525,
  localparam int NMAX = (FRAME_625 > FRAME_525) ? FRAME_625 : FRAME_525,
  localparam int PW   = $clog2(LMAX + 1),
  localparam int LW   = $clog2(NMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master_sel,
  input  logic [1:0]    std_sel,
  input  logic          hsync_n_in,
  input  logic          vsync_n_in,
  output logic          hsync_n_out,
  output logic          vsync_n_out,
  output logic          sync_oe,
  output logic          blank,
  output logic          line_start,
  output logic [LW-1:0] line_num,
  output logic          field
);
  logic [PW-1:0] line_len, half_len, qtr_len, pix;
  logic [LW-1:0] frame_len, mid_line, line;
  logic          sleep, hs_fall, vs_fall, fld, sl_start;

  vsg_std_dec #(
    .LINE_525(LINE_525), .LINE_625(LINE_625),
    .FRAME_525(FRAME_525), .FRAME_625(FRAME_625),
    .PW(PW), .LW(LW)
  ) u_dec (
    .std_sel(std_sel), .line_len(line_len), .half_len(half_len),
    .qtr_len(qtr_len), .frame_len(frame_len), .mid_line(mid_line),
    .sleep(sleep)
  );

  vsg_edge u_edge (
    .clk(clk), .rst(rst), .hsync_n_in(hsync_n_in), .vsync_n_in(vsync_n_in),
    .hs_fall(hs_fall), .vs_fall(vs_fall)
  );

  vsg_counter #(.PW(PW), .LW(LW)) u_cnt (
    .clk(clk), .rst(rst), .master(master_sel), .sleep(sleep),
    .line_len(line_len), .qtr_len(qtr_len), .frame_len(frame_len),
    .mid_line(mid_line), .hs_fall(hs_fall), .vs_fall(vs_fall),
    .pix(pix), .line(line), .fld(fld), .sl_start(sl_start)
  );

  vsg_outreg #(
    .PW(PW), .LW(LW), .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES),
    .H_BLANK(H_BLANK), .VBLANK_LINES(VBLANK_LINES), .FRAME_MAX(NMAX)
  ) u_out (
    .clk(clk), .rst(rst), .master(master_sel), .sleep(sleep),
    .pix(pix), .line(line), .fld(fld), .sl_start(sl_start),
    .half_len(half_len), .mid_line(mid_line),
    .hsync_n_out(hsync_n_out), .vsync_n_out(vsync_n_out),
    .sync_oe(sync_oe), .blank(blank), .line_start(line_start),
    .line_num(line_num), .field(field)
  );

endmodule

// File: tb/vid_sync_gen_tb.sv
module vid_sync_gen_tb;
  localparam int LA = 40, LB = 48, NA = 11, NB = 13;
  localparam int HSW = 6, VSL = 2, HB = 10, VB = 3;
  localparam int LWB = 4;
  localparam int PSAT = 63;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_sel = 1'b1;
  logic [1:0] std_sel = 2'b11;
  logic hsync_n_in = 1'b1;
  logic vsync_n_in = 1'b1;
  logic hsync_n_out, vsync_n_out, sync_oe, blank, line_start, field;
  logic [LWB-1:0] line_num;

  always #10 clk = ~clk;

  vid_sync_gen #(
    .LINE_525(LA), .LINE_625(LB), .FRAME_525(NA), .FRAME_625(NB),
    .HS_WIDTH(HSW), .VS_LINES(VSL), .H_BLANK(HB), .VBLANK_LINES(VB)
  ) u_dut (
    .clk(clk), .rst(rst), .master_sel(master_sel), .std_sel(std_sel),
    .hsync_n_in(hsync_n_in), .vsync_n_in(vsync_n_in),
    .hsync_n_out(hsync_n_out), .vsync_n_out(vsync_n_out), .sync_oe(sync_oe),
    .blank(blank), .line_start(line_start), .line_num(line_num), .field(field)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string phase_tag = "";

  // reference model state
  int p = 0, l = 1, f = 0, ss = 0, hp = 1, vp = 1;
  int e_hs = 1, e_vs = 1, e_oe = 0, e_bl = 1, e_ls = 0, e_line = 1, e_fld = 0;
  int ctx = 0;
  bit model_ok = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int L, N, MID, HALF, QTR, po;
    bit hf, vf, odd, even;
    L    = (std_sel == 2'b10) ? LB : LA;
    N    = (std_sel == 2'b10) ? NB : NA;
    MID  = (N + 1) / 2;
    HALF = L / 2;
    QTR  = L / 4;
    model_ok = 1;
    if (rst) begin
      ctx = 0;
      e_hs = 1; e_vs = 1; e_oe = 0; e_bl = 1; e_ls = 0; e_line = 1; e_fld = 0;
      p = 0; l = 1; f = 0; ss = 0; hp = 1; vp = 1;
    end else begin
      hf = hp && !hsync_n_in;
      vf = vp && !vsync_n_in;
      hp = hsync_n_in;
      vp = vsync_n_in;
      e_oe = master_sel;
      if (std_sel == 2'b00) begin
        ctx = 1;
        e_hs = 1; e_vs = 1; e_bl = 1; e_ls = 0; e_line = 1; e_fld = 0;
        p = 0; l = 1; f = 0; ss = 0;
      end else begin
        e_bl = ((p < HB) || (l <= VB) || (l > MID && l <= MID + VB)) ? 1 : 0;
        e_line = l;
        if (master_sel) begin
          ctx = 2;
          odd  = (l <= VSL);
          even = (l == MID && p >= HALF) || (l > MID && l < MID + VSL) ||
                 (l == MID + VSL && p < HALF);
          e_hs = (p < HSW) ? 0 : 1;
          e_vs = (odd || even) ? 0 : 1;
          e_ls = (p == 0) ? 1 : 0;
          e_fld = ((l > MID) || (l == MID && p >= HALF)) ? 1 : 0;
          ss = 0;
          if (p >= L - 1) begin
            p = 0;
            l = (l >= N) ? 1 : l + 1;
          end else p++;
        end else begin
          ctx = 3;
          e_hs = 1; e_vs = 1; e_ls = ss; e_fld = f;
          po = p;
          ss = hf;
          if (hf) begin
            p = 0;
            l = (l >= N) ? 1 : l + 1;
          end else if (p < PSAT) p++;
          if (vf) begin
            if (hf || po < QTR) begin l = 1; f = 0; end
            else begin l = MID; f = 1; end
          end
        end
      end
    end
  end

  function automatic string tag_for(input int which);
    // which: 0 hs,1 vs,2 oe,3 blank,4 ls,5 line,6 field
    if (phase_tag != "") return phase_tag;
    case (ctx)
      0: return "R1";
      1: return "R9";
      2: case (which)
           0, 4: return "R3";
           1: return "R4/R5";
           2: return "R7";
           3: return "R6";
           5: return "R2";
           default: return "R5";
         endcase
      default: case (which)
           3: return "R6";
           5, 6: return "R8";
           default: return "R7";
         endcase
    endcase
  endfunction

  always @(negedge clk) begin
    if (model_ok && !finished) begin
      chk(hsync_n_out == e_hs[0], tag_for(0), "hsync_n_out", int'(hsync_n_out), e_hs);
      chk(vsync_n_out == e_vs[0], tag_for(1), "vsync_n_out", int'(vsync_n_out), e_vs);
      chk(sync_oe == e_oe[0], tag_for(2), "sync_oe", int'(sync_oe), e_oe);
      chk(blank == e_bl[0], tag_for(3), "blank", int'(blank), e_bl);
      chk(line_start == e_ls[0], tag_for(4), "line_start", int'(line_start), e_ls);
      chk(int'(line_num) == e_line, tag_for(5), "line_num", int'(line_num), e_line);
      chk(field == e_fld[0], tag_for(6), "field", int'(field), e_fld);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // external sync pattern: hsync low for HSW cycles every per cycles,
  // vsync low for VSL*per cycles starting at cycle vstart
  task automatic slave_seq(input int per, input int nlines, input int vstart);
    for (int t = 0; t < per * nlines; t++) begin
      @(negedge clk);
      hsync_n_in = ((t % per) < HSW) ? 1'b0 : 1'b1;
      vsync_n_in = (t >= vstart && t < vstart + VSL * per) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    run(4);
    // R1: idle outputs while reset is held
    chk(hsync_n_out && vsync_n_out && blank && !line_start && !sync_oe &&
        line_num == 4'd1 && !field, "R1", "reset idle", int'(blank), 1);
    rst = 1'b0;
    @(negedge clk);
    // R11: first output cycle after reset shows line 1 cycle 0
    chk(line_start == 1'b1, "R11", "line_start after reset", int'(line_start), 1);
    chk(hsync_n_out == 1'b0, "R11", "hsync after reset", int'(hsync_n_out), 0);
    run(2 * NA * LA);
    std_sel = 2'b01;
    run(NA * LA);
    std_sel = 2'b10;
    run(2 * NB * LB);
    // R10: switch 625 -> 525 late in a line
    phase_tag = "R10";
    while (!line_start) @(negedge clk);
    run(45);
    std_sel = 2'b11;
    run(120);
    phase_tag = "";
    // R9: sleep, then restart
    std_sel = 2'b00;
    run(60);
    std_sel = 2'b11;
    phase_tag = "R9";
    run(3);
    phase_tag = "";
    run(500);
    // slave mode
    master_sel = 1'b0;
    slave_seq(LA, 22, 0);
    slave_seq(LA, 22, 5 * LA + LA / 2);
    slave_seq(LA, 10, 3);
    slave_seq(LA, 10, 2 * LA + 15);
    std_sel = 2'b10;
    slave_seq(LB, 16, 6 * LB + 30);
    slave_seq(80, 6, 80);
    std_sel = 2'b00;
    slave_seq(LA, 2, 0);
    std_sel = 2'b11;
    master_sel = 1'b1;
    run(2 * NA * LA);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule